// File: doc/BRIEF.md
# Integer ALU with trap-selectable overflow

This block is the combinational integer execution unit of a simple RISC core. Two 32-bit operands and a 5-bit shift amount enter. A 4-bit operation code selects one result, and the block returns that 32-bit result together with an overflow-exception flag in the same cycle. The caller sign- or zero-extends any immediate operand before it reaches the unit, so an add-immediate instruction uses the same operation code as the register add.

The supported operations are:

- Addition and subtraction, each in two forms. The trapping form raises the overflow flag when the two's-complement result overflows. The non-trapping form gives the same result bits and never raises the flag.
- Signed and unsigned less-than comparisons.
- Bitwise AND and OR.
- Three shifts of operand A: logical left, logical right and arithmetic right.

The register file, instruction decoding, the exception handler and multiply/divide are outside this block.

Top module: `int_exec_unit`

## Requirements
- R1: Operation codes are 0 trapping add, 1 non-trapping add, 2 trapping subtract, 3 non-trapping subtract. Add returns (A + B) mod 2^32 and subtract returns (A - B) mod 2^32.
- R2: With code 0, the overflow flag is 1 exactly when A + B, taken as two's-complement numbers, falls outside the signed 32-bit range.
- R3: With code 2, the overflow flag is 1 exactly when A - B, taken as two's-complement numbers, falls outside the signed 32-bit range.
- R4: Codes 1 and 3 never raise the overflow flag. Their result equals that of code 0 and code 2 respectively for the same operands.
- R5: Code 4 (signed less-than) returns 1 in bit 0 when A < B as two's-complement numbers, and 0 otherwise. Bits 31..1 are always 0.
- R6: Code 5 (unsigned less-than) returns 1 in bit 0 when A < B as unsigned numbers, and 0 otherwise. Bits 31..1 are always 0. For A = 0xFFFFFFFA and B = 0x0000FFFA, code 4 gives 1 and code 5 gives 0.
- R7: Code 6 returns A AND B and code 7 returns A OR B. Each result bit depends only on the same bit position of A and B.
- R8: Code 8 shifts A left and code 9 shifts A right, each by the shift amount (0 to 31), filling the vacated bits with zeros. A shift amount of 0 returns A unchanged.
- R9: Code 10 shifts A right by the shift amount and fills the vacated bits with copies of A bit 31.
- R10: Codes 11 to 15 return a result of 0 and an overflow flag of 0. Only codes 0 and 2 can ever raise the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (encoding in R1 and R5 to R10) |
| opa_i | input | 32 | Operand A; also the value that is shifted |
| opb_i | input | 32 | Operand B (already extended if it is an immediate) |
| shamt_i | input | 5 | Shift amount, 0 to 31 |
| result_o | output | 32 | Selected result |
| ovf_o | output | 1 | Overflow exception flag |

## Verification
The assertions check, for every input combination that appears, the structural properties of the block:

- the non-trapping forms and the non-arithmetic codes never flag overflow;
- a comparison result has zeros above bit 0;
- a zero shift amount passes A through;
- an unused code returns zero;
- a trapping add that flags overflow had operands of equal sign.

Only the bench's scenarios can show that the numbers themselves are right. It compares every code against a behavioural model, on directed corner values and on random operands. The corner values are the signed range limits, the two comparison operands from R6, negative values for the arithmetic shift, and shift amounts 0 and 31.

// File: rtl/int_exec_pkg.sv
// Package: shared operation codes and widths for the integer execution unit.
// Assumes the 4-bit code space; codes not listed are treated as unused.
package int_exec_pkg;
    localparam int DATA_W = 32;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD_TRAP = 4'd0,
        OP_ADD_WRAP = 4'd1,
        OP_SUB_TRAP = 4'd2,
        OP_SUB_WRAP = 4'd3,
        OP_LT_SIGN  = 4'd4,
        OP_LT_UNS   = 4'd5,
        OP_AND      = 4'd6,
        OP_OR       = 4'd7,
        OP_SHL      = 4'd8,
        OP_SHR_LOG  = 4'd9,
        OP_SHR_ARI  = 4'd10
    } exec_op_e;
endpackage

// File: rtl/iex_addsub.sv
// Module: two's-complement adder/subtractor with raw signed-overflow detection.
// Assumes the caller decides whether the overflow is reported (trapping form).
module iex_addsub #(
    parameter int W = 32
) (
    input  logic         sub_i,
    input  logic         trap_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o
);
    logic [W-1:0] b_eff;
    logic         raw_ovf;

    // Invert B for subtraction and add with carry-in, then detect sign overflow.
    always_comb begin
        b_eff   = sub_i ? ~b_i : b_i;
        sum_o   = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
        raw_ovf = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
        ovf_o   = trap_i & raw_ovf;
    end

    // Guard: a reported add overflow needs operands of equal sign.
    always_comb begin
        if (ovf_o && !sub_i)
            a_r2_same_sign: assert (a_i[W-1] == b_i[W-1])
                else $error("R2 overflow with differing operand signs");
        if (ovf_o && sub_i)
            a_r3_diff_sign: assert (a_i[W-1] != b_i[W-1])
                else $error("R3 subtract overflow with equal operand signs");
        if (!trap_i)
            a_r4_no_overflow: assert (!ovf_o)
                else $error("R4 non-trapping form flagged overflow");
    end
endmodule

// File: rtl/iex_compare.sv
// Module: signed and unsigned less-than producing a zero-extended flag.
// Assumes operands of equal width; flag lands in bit 0.
module iex_compare #(
    parameter int W = 32
) (
    input  logic         signed_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] lt_o
);
    logic lt_s;
    logic lt_u;
    logic lt_sel;

    // Compute both flavours and pick one; signed differs only when signs differ.
    always_comb begin
        lt_u   = (a_i < b_i);
        lt_s   = (a_i[W-1] != b_i[W-1]) ? a_i[W-1] : lt_u;
        lt_sel = signed_i ? lt_s : lt_u;
        lt_o   = {{(W-1){1'b0}}, lt_sel};
    end

    // Guard: upper bits of a comparison are always zero.
    always_comb begin
        a_r5_upper_zero: assert (lt_o[W-1:1] == '0)
            else $error("R5 comparison upper bits not zero");
        if (!signed_i && a_i == b_i)
            a_r6_equal_not_less: assert (lt_o[0] == 1'b0)
                else $error("R6 equal operands reported less");
    end
endmodule

// File: rtl/iex_shifter.sv
// Module: logarithmic barrel shifter for left-logical, right-logical, right-arithmetic.
// Assumes shift amount width is clog2 of the data width; left shifts reuse the
// right-shift stages through bit reversal.
module iex_shifter #(
    parameter int W  = 32,
    localparam int SW = $clog2(W)
) (
    input  logic          left_i,
    input  logic          arith_i,
    input  logic [SW-1:0] amt_i,
    input  logic [W-1:0]  a_i,
    output logic [W-1:0]  y_o
);
    logic [W-1:0] a_rev;
    logic [W-1:0] stage [0:SW];
    logic [W-1:0] out_rev;
    logic         fill;

    genvar gi;
    // Bit-reverse the input and the final stage for left shifts.
    generate
        for (gi = 0; gi < W; gi++) begin : g_rev
            assign a_rev[gi]   = a_i[W-1-gi];
            assign out_rev[gi] = stage[SW][W-1-gi];
        end
    endgenerate

    assign fill     = arith_i & ~left_i & a_i[W-1];
    assign stage[0] = left_i ? a_rev : a_i;

    // One conditional power-of-two right shift per amount bit.
    generate
        for (gi = 0; gi < SW; gi++) begin : g_stage
            localparam int S = 1 << gi;
            assign stage[gi+1] = amt_i[gi]
                ? {{S{fill}}, stage[gi][W-1:S]}
                : stage[gi];
        end
    endgenerate

    assign y_o = left_i ? out_rev : stage[SW];

    // Guard: zero amount passes the operand through; arithmetic keeps the sign.
    always_comb begin
        if (amt_i == '0)
            a_r8_zero_amount: assert (y_o == a_i)
                else $error("R8 zero shift changed operand");
        if (arith_i && !left_i)
            a_r9_sign_kept: assert (y_o[W-1] == a_i[W-1])
                else $error("R9 arithmetic shift lost sign");
    end
endmodule

// File: rtl/int_exec_unit.sv
// Module: top of the combinational integer execution unit. Decodes the
// operation code, drives the arithmetic, compare and shift units and selects
// the result. Assumes immediates arrive already extended; purely combinational.
module int_exec_unit
    import int_exec_pkg::*;
#(
    parameter int W  = DATA_W,
    localparam int SW = $clog2(W)
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    opa_i,
    input  logic [W-1:0]    opb_i,
    input  logic [SW-1:0]   shamt_i,
    output logic [W-1:0]    result_o,
    output logic            ovf_o
);
    exec_op_e     op;
    logic         is_sub;
    logic         is_trap;
    logic         is_signed_cmp;
    logic         sh_left;
    logic         sh_arith;
    logic [W-1:0] sum;
    logic         as_ovf;
    logic [W-1:0] lt_word;
    logic [W-1:0] sh_word;

    assign op = exec_op_e'(op_i);

    // Decode control bits for the sub-units.
    always_comb begin
        is_sub        = (op == OP_SUB_TRAP) || (op == OP_SUB_WRAP);
        is_trap       = (op == OP_ADD_TRAP) || (op == OP_SUB_TRAP);
        is_signed_cmp = (op == OP_LT_SIGN);
        sh_left       = (op == OP_SHL);
        sh_arith      = (op == OP_SHR_ARI);
    end

    iex_addsub #(.W(W)) u_addsub (
        .sub_i  (is_sub),
        .trap_i (is_trap),
        .a_i    (opa_i),
        .b_i    (opb_i),
        .sum_o  (sum),
        .ovf_o  (as_ovf)
    );

    iex_compare #(.W(W)) u_compare (
        .signed_i (is_signed_cmp),
        .a_i      (opa_i),
        .b_i      (opb_i),
        .lt_o     (lt_word)
    );

    iex_shifter #(.W(W)) u_shifter (
        .left_i  (sh_left),
        .arith_i (sh_arith),
        .amt_i   (shamt_i),
        .a_i     (opa_i),
        .y_o     (sh_word)
    );

    // Select the result for the current code; unused codes give zero.
    always_comb begin
        result_o = '0;
        case (op)
            OP_ADD_TRAP, OP_ADD_WRAP,
            OP_SUB_TRAP, OP_SUB_WRAP:   result_o = sum;
            OP_LT_SIGN, OP_LT_UNS:      result_o = lt_word;
            OP_AND:                     result_o = opa_i & opb_i;
            OP_OR:                      result_o = opa_i | opb_i;
            OP_SHL, OP_SHR_LOG,
            OP_SHR_ARI:                 result_o = sh_word;
            default:                    result_o = '0;
        endcase
    end

    // Only arithmetic codes may report overflow.
    always_comb begin
        ovf_o = as_ovf & (op_i <= 4'd3);
    end

    // Guard: unused codes are silent; flag only for trapping codes.
    always_comb begin
        if (op_i > 4'd10)
            a_r10_unused_zero: assert (result_o == '0 && !ovf_o)
                else $error("R10 unused code produced output");
        if (ovf_o)
            a_r10_trap_only: assert (op_i == 4'd0 || op_i == 4'd2)
                else $error("R10 overflow on non-trapping code");
    end
endmodule

// File: tb/test_int_exec_unit.sv
// Bench: drives the unit once per clock and compares it with a behavioural model.
module test_int_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op;
    logic [31:0] a, b;
    logic [4:0]  sh;
    logic [31:0] res;
    logic        ovf;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    int_exec_unit i_int_exec_unit (
        .op_i(op), .opa_i(a), .opb_i(b), .shamt_i(sh),
        .result_o(res), .ovf_o(ovf)
    );

    // Behavioural reference: returns {overflow, result}.
    function automatic logic [32:0] model(logic [3:0] c, logic [31:0] x,
                                          logic [31:0] y, logic [4:0] s);
        longint sx = longint'($signed(x));
        longint sy = longint'($signed(y));
        longint t;
        logic   v;
        case (c)
            0, 1: begin
                t = sx + sy;
                v = (t > 64'sd2147483647) || (t < -64'sd2147483648);
                return {v & (c == 0), 32'(x + y)};
            end
            2, 3: begin
                t = sx - sy;
                v = (t > 64'sd2147483647) || (t < -64'sd2147483648);
                return {v & (c == 2), 32'(x - y)};
            end
            4:  return {1'b0, 31'd0, sx < sy};
            5:  return {1'b0, 31'd0, x < y};
            6:  return {1'b0, x & y};
            7:  return {1'b0, x | y};
            8:  return {1'b0, x << s};
            9:  return {1'b0, x >> s};
            10: return {1'b0, 32'($signed(x) >>> s)};
            default: return 33'd0;
        endcase
    endfunction

    function automatic string tag(logic [3:0] c);
        case (c)
            0: return "R2/R1";  1: return "R4/R1";
            2: return "R3/R1";  3: return "R4/R1";
            4: return "R5";     5: return "R6";
            6, 7: return "R7";  8, 9: return "R8";
            10: return "R9";    default: return "R10";
        endcase
    endfunction

    // Apply one vector after a rising edge and check it at the falling edge.
    task automatic apply(input logic [3:0] c, input logic [31:0] x,
                         input logic [31:0] y, input logic [4:0] s);
        logic [32:0] exp;
        @(posedge clk);
        op = c; a = x; b = y; sh = s;
        @(negedge clk);
        exp = model(c, x, y, s);
        n_chk++;
        if ({ovf, res} !== exp) begin
            n_err++;
            $display("FAIL %s op=%0d a=%h b=%h sh=%0d: got ovf=%b res=%h exp ovf=%b res=%h",
                     tag(c), c, x, y, s, ovf, res, exp[32], exp[31:0]);
        end
    endtask

    initial begin
        op = 4'd15; a = '0; b = '0; sh = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset-time state: an unused code with zero operands gives nothing (R10).
        apply(4'd15, 32'h0, 32'h0, 5'd0);
        // R1/R2: plain add, positive overflow, negative overflow, no overflow on mixed signs.
        apply(4'd0, 32'd5, 32'd7, 5'd0);
        apply(4'd0, 32'h7FFFFFFF, 32'd1, 5'd0);
        apply(4'd0, 32'h80000000, 32'hFFFFFFFF, 5'd0);
        apply(4'd0, 32'h7FFFFFFF, 32'h80000000, 5'd0);
        // R3: subtract overflow both ways, and a limit case that does not overflow.
        apply(4'd2, 32'h80000000, 32'd1, 5'd0);
        apply(4'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0);
        apply(4'd2, 32'hFFFFFFFF, 32'h7FFFFFFF, 5'd0);
        apply(4'd2, 32'd0, 32'h80000000, 5'd0);
        // R4: non-trapping forms on the same overflowing operands.
        apply(4'd1, 32'h7FFFFFFF, 32'd1, 5'd0);
        apply(4'd3, 32'h80000000, 32'd1, 5'd0);
        // R5/R6: the documented operand pair and the equal case.
        apply(4'd4, 32'hFFFFFFFA, 32'h0000FFFA, 5'd0);
        apply(4'd5, 32'hFFFFFFFA, 32'h0000FFFA, 5'd0);
        apply(4'd5, 32'h1234, 32'h1234, 5'd0);
        apply(4'd4, 32'h80000000, 32'h7FFFFFFF, 5'd0);
        // R7: masking and forcing bits.
        apply(4'd6, 32'hB6A43D9A, 32'h00000FFF, 5'd0);
        apply(4'd7, 32'h12345678, 32'h0000FFFF, 5'd0);
        // R8/R9: shift edges, amounts 0, 8 and 31.
        apply(4'd8, 32'h12345678, 32'h0, 5'd8);
        apply(4'd9, 32'h12345678, 32'h0, 5'd8);
        apply(4'd10, 32'h92345678, 32'h0, 5'd8);
        apply(4'd10, 32'h12345678, 32'h0, 5'd8);
        apply(4'd8, 32'hDEADBEEF, 32'h0, 5'd0);
        apply(4'd9, 32'h80000000, 32'h0, 5'd31);
        apply(4'd10, 32'h80000000, 32'h0, 5'd31);
        apply(4'd8, 32'hFFFFFFFF, 32'h0, 5'd31);
        // R10: every unused code with busy operands.
        for (int c = 11; c < 16; c++)
            apply(4'(c), 32'hFFFFFFFF, 32'h7FFFFFFF, 5'd3);
        // Random sweep across every code.
        for (int k = 0; k < 2000; k++)
            apply(4'($urandom_range(0, 15)), $urandom, $urandom, 5'($urandom));
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule